// File: doc/BRIEF.md
# Accumulator Shifter with One-Shot Indirect Count

This block is the shift stage of a fixed-point audio DSP datapath. It works on a 34-bit word. The top 4 bits are a sign extension, the next 24 bits are data and the bottom 6 bits are guard bits. Each clock cycle is one instruction step. In each step the instruction's 4-bit shift code picks one of these: pass the operand through, shift it left or right by a fixed amount, or build one of two double-precision helper words. The result is combinational from the current inputs and one small piece of stored state.

That state is a 5-bit indirect shift count, loaded from the top of the data bus by a load strobe. A loaded count is used in exactly the next step. In that step it overrides whatever the shift code says, and after it the stored count no longer applies. With a magnitude detector outside this block, this lets software normalise a value in two steps.

The two helper modes support double-precision multiplication. The low-part mode places the low 15 product bits in the middle of an otherwise zero word. The high-part mode takes the top 13 bits of data register 0 through a dedicated input, sign-extends them and places them at the same position.

Top module: `acc_shifter`

## Requirements
- R1: With no override pending, shift code 0 and the unused codes 11 to 15 return the operand unchanged on all 34 bits.
- R2: Codes 1, 2, 3 and 4 shift the operand left by 1, 2, 4 and 8 bits. Zeros fill from bit 0 and bits moved past bit 33 are lost, with no saturation. For example, 24-bit data 0x163AFE held in bits [29:6] becomes 0x58EBF8 with code 2.
- R3: Codes 5, 6, 7 and 8 shift the operand right arithmetically by 1, 2, 4 and 8 bits, copying bit 33 into the vacated upper bits.
- R4: Code 9 (low part) returns operand bits [14:0] placed at result bits [20:6], with result bits [33:21] and [5:0] all zero.
- R5: Code 10 (high part) returns bits [33:21] of the data register 0 input placed at result bits [18:6]. Result bits [33:19] all copy data register 0 bit 33 and result bits [5:0] are zero. The operand input has no effect in this mode.
- R6: A rising clock edge that sees the load strobe high captures data bus bits [23:19] as the indirect count.
- R7: In the step right after a load, the captured count overrides every shift code, including codes 9 and 10. The count is read as two's complement: values 0 to 15 shift left by that amount, and values -1 to -16 shift right arithmetically by the magnitude.
- R8: The override lasts one step only. If the following edge does not see a new load, the next step again follows its shift code. Back-to-back loads each apply to the step after their own edge.
- R9: After reset no override is pending, so the first step follows its shift code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Step clock, one instruction per rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 34 | Operand word (extension, data, guard bits) |
| dr0_i | input | 34 | Direct path from data register 0, used by the high-part mode |
| shf_code_i | input | 4 | Instruction shift code |
| dbus_i | input | 24 | Data bus; bits [23:19] hold the indirect count |
| ind_load_i | input | 1 | Load strobe for the indirect count |
| res_o | output | 34 | Shifted result word |

## Verification
Every cycle, the assertions check the following:
- a load arms the override with the bus value, and an armed override drops after one step unless it is reloaded;
- the zero fields of the low-part and high-part words are present, and the upper sign field of the high-part word is consistent;
- a pass-through code, or a zero indirect count, leaves the operand untouched.

Only the bench scenarios can show the following:
- the exact shift amounts and fill bits of every direct code;
- the two's-complement reading of the indirect count up to a right shift of 16;
- that the override beats the helper modes;
- the order in which back-to-back loads take effect.

These are compared against a bit-by-bit model over directed and random steps.

// File: rtl/acc_shf_pkg.sv
package acc_shf_pkg;
  localparam int WORD_W  = 34;
  localparam int GUARD_W = 6;
  localparam int CNT_W   = 5;
  localparam int CODE_W  = 4;
  localparam int SPLIT_W = 15;  // product bits kept by the low-part mode
  localparam int HI_W    = 13;  // register bits kept by the high-part mode

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  amt_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [2:0] {
    MODE_PASS,
    MODE_SHL,
    MODE_SHR,
    MODE_LOW,
    MODE_HIGH
  } mode_e;

  typedef struct packed {
    mode_e mode;
    amt_t  amt;
  } op_sel_t;

  localparam code_t CODE_NONE = 4'd0;
  localparam code_t CODE_L1   = 4'd1;
  localparam code_t CODE_L2   = 4'd2;
  localparam code_t CODE_L4   = 4'd3;
  localparam code_t CODE_L8   = 4'd4;
  localparam code_t CODE_R1   = 4'd5;
  localparam code_t CODE_R2   = 4'd6;
  localparam code_t CODE_R4   = 4'd7;
  localparam code_t CODE_R8   = 4'd8;
  localparam code_t CODE_LOW  = 4'd9;
  localparam code_t CODE_HIGH = 4'd10;

  // Map an instruction shift code to a mode and an amount.
  function automatic op_sel_t decode_code(input code_t c);
    op_sel_t s;
    s.mode = MODE_PASS;
    s.amt  = '0;
    case (c)
      CODE_L1:   begin s.mode = MODE_SHL; s.amt = 5'd1; end
      CODE_L2:   begin s.mode = MODE_SHL; s.amt = 5'd2; end
      CODE_L4:   begin s.mode = MODE_SHL; s.amt = 5'd4; end
      CODE_L8:   begin s.mode = MODE_SHL; s.amt = 5'd8; end
      CODE_R1:   begin s.mode = MODE_SHR; s.amt = 5'd1; end
      CODE_R2:   begin s.mode = MODE_SHR; s.amt = 5'd2; end
      CODE_R4:   begin s.mode = MODE_SHR; s.amt = 5'd4; end
      CODE_R8:   begin s.mode = MODE_SHR; s.amt = 5'd8; end
      CODE_LOW:  s.mode = MODE_LOW;
      CODE_HIGH: s.mode = MODE_HIGH;
      default:   s.mode = MODE_PASS;
    endcase
    return s;
  endfunction

  // Two's-complement count: non-negative shifts left, negative shifts right.
  function automatic op_sel_t indirect_sel(input amt_t c);
    op_sel_t s;
    if (c[CNT_W-1]) begin
      s.mode = MODE_SHR;
      s.amt  = amt_t'(~c + 1'b1);
    end else begin
      s.mode = MODE_SHL;
      s.amt  = c;
    end
    return s;
  endfunction

  function automatic word_t shift_left(input word_t w, input amt_t n);
    return w << n;
  endfunction

  function automatic word_t shift_right_arith(input word_t w, input amt_t n);
    return word_t'($signed(w) >>> n);
  endfunction

  function automatic word_t low_part(input word_t p);
    return {{(WORD_W-SPLIT_W-GUARD_W){1'b0}}, p[SPLIT_W-1:0], {GUARD_W{1'b0}}};
  endfunction

  function automatic word_t high_part(input word_t d);
    return {{(WORD_W-HI_W-GUARD_W){d[WORD_W-1]}}, d[WORD_W-1 -: HI_W], {GUARD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/acc_shf_ind_reg.sv
module acc_shf_ind_reg
  import acc_shf_pkg::*;
#(
  parameter int DBUS_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DBUS_W-1:0] dbus_i,
  output logic              act_o,
  output amt_t              cnt_o
);
  localparam int LOW_W = DBUS_W - CNT_W;

  amt_t bus_cnt;
  logic unused_bus_low;

  assign bus_cnt        = dbus_i[DBUS_W-1 -: CNT_W];
  assign unused_bus_low = ^dbus_i[LOW_W-1:0];

  // The flag arms on a load and falls on any step without one.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b0;
      cnt_o <= '0;
    end else begin
      act_o <= load_i;
      if (load_i) cnt_o <= bus_cnt;
    end
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (act_o && cnt_o == $past(dbus_i[DBUS_W-1 -: CNT_W]))); // R6
  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> !act_o); // R8
endmodule

// File: rtl/acc_shf_core.sv
module acc_shf_core
  import acc_shf_pkg::*;
(
  input  word_t op_i,
  input  word_t dr0_i,
  input  code_t code_i,
  input  logic  ind_act_i,
  input  amt_t  ind_cnt_i,
  output word_t res_o
);
  op_sel_t sel_direct;
  op_sel_t sel_ind;
  op_sel_t sel;

  assign sel_direct = decode_code(code_i);
  assign sel_ind    = indirect_sel(ind_cnt_i);
  assign sel        = ind_act_i ? sel_ind : sel_direct;

  always_comb begin
    case (sel.mode)
      MODE_SHL:  res_o = shift_left(op_i, sel.amt);
      MODE_SHR:  res_o = shift_right_arith(op_i, sel.amt);
      MODE_LOW:  res_o = low_part(op_i);
      MODE_HIGH: res_o = high_part(dr0_i);
      default:   res_o = op_i;
    endcase
  end
endmodule

// File: rtl/acc_shifter.sv
module acc_shifter
  import acc_shf_pkg::*;
#(
  parameter int DBUS_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [33:0]       op_i,
  input  logic [33:0]       dr0_i,
  input  logic [3:0]        shf_code_i,
  input  logic [DBUS_W-1:0] dbus_i,
  input  logic              ind_load_i,
  output logic [33:0]       res_o
);
  logic ind_act;
  amt_t ind_cnt;

  acc_shf_ind_reg #(.DBUS_W(DBUS_W)) ind_reg_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ind_load_i),
    .dbus_i (dbus_i),
    .act_o  (ind_act),
    .cnt_o  (ind_cnt)
  );

  acc_shf_core core_i (
    .op_i      (op_i),
    .dr0_i     (dr0_i),
    .code_i    (shf_code_i),
    .ind_act_i (ind_act),
    .ind_cnt_i (ind_cnt),
    .res_o     (res_o)
  );

  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ind_act && (shf_code_i == CODE_NONE || shf_code_i > CODE_HIGH)) |-> res_o == op_i); // R1
  AST_LOWPART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ind_act && shf_code_i == CODE_LOW) |-> (res_o[33:21] == '0 && res_o[5:0] == '0)); // R4
  AST_HIGHPART_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ind_act && shf_code_i == CODE_HIGH) |->
      (res_o[5:0] == '0 && $countones(res_o[33:18]) inside {0, 16})); // R5
  AST_ZERO_INDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ind_act && ind_cnt == '0) |-> res_o == op_i); // R7
endmodule

// File: tb/acc_shifter_tb.sv
`timescale 1ns/1ps
module acc_shifter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [33:0] op_i = '0;
  logic [33:0] dr0_i = '0;
  logic [3:0]  shf_code_i = '0;
  logic [23:0] dbus_i = '0;
  logic        ind_load_i = 1'b0;
  logic [33:0] res_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit m_act = 0;
  logic [4:0] m_cnt = '0;

  always #4 clk_i = ~clk_i;

  acc_shifter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .dr0_i(dr0_i),
    .shf_code_i(shf_code_i), .dbus_i(dbus_i), .ind_load_i(ind_load_i), .res_o(res_o)
  );

  function automatic logic [33:0] sl(input logic [33:0] v, input int n);
    logic [33:0] r = v;
    for (int i = 0; i < n; i++) r = {r[32:0], 1'b0};
    return r;
  endfunction

  function automatic logic [33:0] sra(input logic [33:0] v, input int n);
    logic [33:0] r = v;
    for (int i = 0; i < n; i++) r = {r[33], r[33:1]};
    return r;
  endfunction

  function automatic logic [33:0] model(input logic [33:0] op, input logic [33:0] dr0,
                                        input logic [3:0] code, input bit act, input logic [4:0] cnt);
    logic [33:0] r = '0;
    int n;
    if (act) begin
      n = int'($signed(cnt));
      return (n >= 0) ? sl(op, n) : sra(op, -n);
    end
    case (code)
      4'd1: r = sl(op, 1);
      4'd2: r = sl(op, 2);
      4'd3: r = sl(op, 4);
      4'd4: r = sl(op, 8);
      4'd5: r = sra(op, 1);
      4'd6: r = sra(op, 2);
      4'd7: r = sra(op, 4);
      4'd8: r = sra(op, 8);
      4'd9: for (int i = 0; i < 15; i++) r[i+6] = op[i];
      4'd10: begin
        for (int i = 0; i < 13; i++) r[i+6] = dr0[i+21];
        for (int i = 19; i < 34; i++) r[i] = dr0[33];
      end
      default: r = op;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] code, input bit act);
    if (act) return "R7";
    if (code inside {[4'd1:4'd4]}) return "R2";
    if (code inside {[4'd5:4'd8]}) return "R3";
    if (code == 4'd9) return "R4";
    if (code == 4'd10) return "R5";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic [33:0] act_v, input logic [33:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: res_o=%h expected %h", tag, act_v, exp_v);
    end
  endtask

  task automatic step(input logic [33:0] op, input logic [33:0] dr0, input logic [3:0] code,
                      input bit ld, input logic [4:0] cnt, input string tag);
    string t;
    @(negedge clk_i);
    op_i = op; dr0_i = dr0; shf_code_i = code; ind_load_i = ld;
    dbus_i = {cnt, 19'($urandom)};
    #1;
    t = (tag == "") ? tag_of(code, m_act) : tag;
    check(t, res_o, model(op, dr0, code, m_act, m_cnt));
    @(posedge clk_i);
    m_act = ld;
    if (ld) m_cnt = cnt;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: res_o=%h expected completion", res_o);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R9: first step after reset follows its code
    step(34'h2_5A5A_5A5A, '0, 4'd0, 0, 5'd0, "R9");
    step(34'h1_2345_6789, '0, 4'd13, 0, 5'd0, "R1");
    // R2 normalisation example: 0x163AFE -> 0x58EBF8 in bits [29:6]
    step(34'h163AFE << 6, '0, 4'd2, 0, 5'd0, "R2");
    check("R2", res_o, 34'h58EBF8 << 6);
    step(34'h3_FFFF_FFFF, '0, 4'd4, 0, 5'd0, "R2");
    step(34'h2_0000_0000, '0, 4'd8, 0, 5'd0, "R3");
    step(34'h1_8000_0001, '0, 4'd5, 0, 5'd0, "R3");
    step(34'h3_FFFF_FFFF, '0, 4'd9, 0, 5'd0, "R4");
    step(34'h1_2345_6789, 34'h2_AAAA_5555, 4'd10, 0, 5'd0, "R5");
    step(34'h3_FFFF_FFFF, 34'h1_5555_AAAA, 4'd10, 0, 5'd0, "R5");
    // R6/R7: load +2, next step overrides high-part code; R8 then clears
    step(34'h0_0000_1111, '0, 4'd0, 1, 5'd2, "R6");
    step(34'h0_0163_AFE0, 34'h3_0000_0000, 4'd10, 0, 5'd0, "R7");
    step(34'h0_0163_AFE0, 34'h3_0000_0000, 4'd10, 0, 5'd0, "R8");
    // R7: -16 gives arithmetic right 16, overriding low-part code
    step('0, '0, 4'd0, 1, 5'h10, "R6");
    step(34'h2_1234_5678, '0, 4'd9, 0, 5'd0, "R7");
    // R7: +15 and -1 limits
    step('0, '0, 4'd0, 1, 5'hF, "R6");
    step(34'h0_0000_0003, '0, 4'd5, 0, 5'd0, "R7");
    // R8: back-to-back loads apply in order
    step('0, '0, 4'd0, 1, 5'h1F, "R6");
    step(34'h2_0000_0010, '0, 4'd4, 1, 5'd3, "R8");
    step(34'h0_0000_0010, '0, 4'd7, 0, 5'd0, "R8");
    step(34'h0_0000_0010, '0, 4'd7, 0, 5'd0, "R8");
    // random mix
    for (int i = 0; i < 400; i++) begin
      step({$urandom, $urandom} & 34'h3_FFFF_FFFF, {$urandom, $urandom} & 34'h3_FFFF_FFFF,
           4'($urandom), ($urandom % 4) == 0, 5'($urandom), "");
    end
    finish_run();
  end
endmodule